// File: doc/BRIEF.md
# Multi-Lane Synchronous Serial Master

This block is the master side of a synchronous serial link that can move data over one, two or four data lanes. Software-facing logic pushes 16-bit command entries into a small transmit queue; each entry carries a data byte, a format tag and an end-of-message flag. The engine pops entries one at a time. It drives a low-active frame select, a divided serial clock and the data lanes. Bits arriving from the remote device are collected into bytes and placed in a receive queue.

The format and the frame ending are chosen per entry and not by a global mode register. Consecutive entries in one frame may therefore use different lane widths. The serial clock runs only while an entry is being shifted. A read therefore needs a dummy transmit entry to generate clocks. When the transmit queue runs dry in the middle of a frame, the clock stops and frame select keeps its level until more entries arrive.

Top module: `mlss_master`

## Requirements
- R1: After reset, `fss_o` is high, `sck_o` is low, `lane_oe_o` is 0 and `rx_valid_o` is low.
- R2: When an entry is waiting and `fss_o` is high, `fss_o` goes low before the first rising edge of `sck_o` for that entry.
- R3: Entry bits [15:13] select the format: 1 is dual-lane, 2 is quad-lane, 3 is advanced single-lane, and any other value is legacy single-lane. Bits [7:0] hold the byte. Bits leave most significant first. Within a multi-lane beat, the higher lane index carries the more significant bit.
- R4: `sck_o` stays high for exactly SCK_DIV/2 system clocks per beat and low for at least SCK_DIV/2. `lane_o` never changes while `sck_o` is high.
- R5: When entry bit 12 is set, `fss_o` goes high at the falling edge that ends that entry's last beat. Without it, `fss_o` stays low across consecutive entries.
- R6: When the transmit queue is empty and `fss_o` is low, `fss_o` stays low and `sck_o` produces no edges.
- R7: In dual or quad format with `dir_rx_i` low, lanes 0..1 or 0..3 are driven (`lane_oe_o` = 4'b0011 or 4'b1111) and nothing enters the receive queue.
- R8: In dual or quad format with `dir_rx_i` high, `lane_oe_o` is 0. Each beat samples lanes 0..1 or 0..3 on the rising edge, and the assembled byte is pushed.
- R9: In advanced format, lane 0 transmits with `lane_oe_o` = 4'b0001. Nothing is received when `dir_rx_i` is low. When `dir_rx_i` is high, the byte sampled on lane 1 is pushed while lane 0 transmits.
- R10: In legacy format, lane 0 transmits and lane 1 is sampled on every entry, whatever the value of `dir_rx_i`.
- R11: Every receive entry holds the byte in bits [7:0], and bits [15:8] are zero.
- R12: `dir_rx_i` is sampled when an entry is popped. Changing it during the entry has no effect until the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Transmit entry offered |
| tx_data_i | input | 16 | Transmit entry: tag [15:13], end flag [12], byte [7:0] |
| tx_ready_o | output | 1 | Transmit queue has room |
| dir_rx_i | input | 1 | Direction for the next entry: 1 receive, 0 transmit |
| rx_valid_o | output | 1 | Receive entry available |
| rx_data_o | output | 16 | Receive entry, byte in [7:0] |
| rx_ready_i | input | 1 | Pop the receive entry |
| fss_o | output | 1 | Frame select, active low |
| sck_o | output | 1 | Serial clock, idle low |
| lane_o | output | 4 | Data lane outputs |
| lane_oe_o | output | 4 | Per-lane output enable |
| lane_i | input | 4 | Data lane inputs |

## Verification
The assertions check the cycle-level rules on every cycle. Lanes hold steady while the clock is high, and frame select moves only while the clock is low. The clock never runs outside a frame, and output enables take only legal shapes. Receive pushes never happen for a transmit-direction multi-lane or advanced entry, and they always carry a zero high byte. The bench scenarios cover what needs a whole-entry view. They check bit order and lane mapping for each format and the exact clock high time. They also cover frame-select behaviour across an underrun and an end flag, and the latching of direction at pop time.

// File: rtl/mlss_pkg.sv
package mlss_pkg;

  typedef enum logic [1:0] {
    FMT_LEGACY = 2'd0,
    FMT_DUAL   = 2'd1,
    FMT_QUAD   = 2'd2,
    FMT_ADV    = 2'd3
  } fmt_e;

  localparam int TAG_MSB  = 15;
  localparam int TAG_LSB  = 13;
  localparam int EOM_BIT  = 12;
  localparam int BYTE_W   = 8;
  localparam int LANES    = 4;
  localparam int ENTRY_W  = 16;

  function automatic fmt_e decode_tag(input logic [2:0] tag);
    case (tag)
      3'd1:    return FMT_DUAL;
      3'd2:    return FMT_QUAD;
      3'd3:    return FMT_ADV;
      default: return FMT_LEGACY;
    endcase
  endfunction

  function automatic int lanes_of(input fmt_e f);
    case (f)
      FMT_DUAL: return 2;
      FMT_QUAD: return 4;
      default:  return 1;
    endcase
  endfunction

  function automatic int beats_of(input fmt_e f);
    return BYTE_W / lanes_of(f);
  endfunction

endpackage

// File: rtl/mlss_fifo.sv
module mlss_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] rdata_o
);
  localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wp_q, rp_q;
  logic         do_push, do_pop;

  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign valid_o = (wp_q != rp_q);
  assign rdata_o = mem_q[rp_q[AW-1:0]];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q[AW-1:0]] <= wdata_i;
  end

endmodule

// File: rtl/mlss_ctrl.sv
module mlss_ctrl
  import mlss_pkg::*;
#(
  parameter int SCK_DIV = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_valid_i,
  input  logic [ENTRY_W-1:0] tx_entry_i,
  input  logic               dir_rx_i,
  output logic               load_o,
  output logic               sample_o,
  output logic               shift_o,
  output logic               done_o,
  output logic               rx_push_o,
  output logic               active_o,
  output logic               fss_o,
  output logic               sck_o,
  output fmt_e               fmt_o,
  output logic               dir_o
);
  localparam int HALF = (SCK_DIV < 2) ? 1 : SCK_DIV / 2;
  localparam int CW   = $clog2(HALF + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} st_e;

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    beat_q;
  fmt_e          fmt_q;
  logic          dir_q, eom_q, fss_q, sck_q;
  logic          cnt_done, last_beat;

  always_comb begin
    cnt_done  = (cnt_q == CW'(HALF - 1));
    last_beat = (beat_q == 3'(beats_of(fmt_q) - 1));
    load_o    = (st_q == ST_IDLE) && tx_valid_i && !fss_q;
    sample_o  = (st_q == ST_LOW)  && cnt_done;
    shift_o   = (st_q == ST_HIGH) && cnt_done && !last_beat;
    done_o    = (st_q == ST_HIGH) && cnt_done && last_beat;
    // multi-lane and advanced receive only in receive direction
    rx_push_o = done_o && ((fmt_q == FMT_LEGACY) || dir_q);
    active_o  = (st_q != ST_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      beat_q <= '0;
      fmt_q  <= FMT_LEGACY;
      dir_q  <= 1'b0;
      eom_q  <= 1'b0;
      fss_q  <= 1'b1;
      sck_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (tx_valid_i) begin
            if (fss_q) begin
              fss_q <= 1'b0;
            end else begin
              fmt_q  <= decode_tag(tx_entry_i[TAG_MSB:TAG_LSB]);
              dir_q  <= dir_rx_i;
              eom_q  <= tx_entry_i[EOM_BIT];
              beat_q <= '0;
              cnt_q  <= '0;
              st_q   <= ST_LOW;
            end
          end
        end
        ST_LOW: begin
          if (cnt_done) begin
            cnt_q <= '0;
            sck_q <= 1'b1;
            st_q  <= ST_HIGH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt_done) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
            if (last_beat) begin
              st_q <= ST_IDLE;
              if (eom_q) fss_q <= 1'b1;
            end else begin
              beat_q <= beat_q + 1'b1;
              st_q   <= ST_LOW;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign fss_o = fss_q;
  assign sck_o = sck_q;
  assign fmt_o = fmt_q;
  assign dir_o = dir_q;

endmodule

// File: rtl/mlss_shift.sv
module mlss_shift
  import mlss_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              active_i,
  input  fmt_e              fmt_i,
  input  logic              dir_i,
  input  logic [LANES-1:0]  lane_i,
  output logic [LANES-1:0]  lane_o,
  output logic [LANES-1:0]  lane_oe_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  logic [BYTE_W-1:0] tx_sh_q, rx_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q <= '0;
    end else if (load_i) begin
      tx_sh_q <= data_i;
    end else if (shift_i) begin
      case (fmt_i)
        FMT_DUAL: tx_sh_q <= {tx_sh_q[BYTE_W-3:0], 2'b00};
        FMT_QUAD: tx_sh_q <= {tx_sh_q[BYTE_W-5:0], 4'b0000};
        default:  tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
      endcase
    end
  end

  // input bits registered on the rising serial edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh_q <= '0;
    end else if (sample_i) begin
      case (fmt_i)
        FMT_DUAL: rx_sh_q <= {rx_sh_q[BYTE_W-3:0], lane_i[1:0]};
        FMT_QUAD: rx_sh_q <= {rx_sh_q[BYTE_W-5:0], lane_i};
        default:  rx_sh_q <= {rx_sh_q[BYTE_W-2:0], lane_i[1]};
      endcase
    end
  end

  always_comb begin
    case (fmt_i)
      FMT_DUAL: lane_o = {2'b00, tx_sh_q[BYTE_W-1 -: 2]};
      FMT_QUAD: lane_o = tx_sh_q[BYTE_W-1 -: 4];
      default:  lane_o = {3'b000, tx_sh_q[BYTE_W-1]};
    endcase
    if (!active_i) begin
      lane_oe_o = '0;
    end else begin
      case (fmt_i)
        FMT_DUAL: lane_oe_o = dir_i ? 4'b0000 : 4'b0011;
        FMT_QUAD: lane_oe_o = dir_i ? 4'b0000 : 4'b1111;
        default:  lane_oe_o = 4'b0001;
      endcase
    end
  end

  assign rx_byte_o = rx_sh_q;

endmodule

// File: rtl/mlss_master.sv
module mlss_master
  import mlss_pkg::*;
#(
  parameter int SCK_DIV  = 4,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_valid_i,
  input  logic [15:0] tx_data_i,
  output logic        tx_ready_o,
  input  logic        dir_rx_i,
  output logic        rx_valid_o,
  output logic [15:0] rx_data_o,
  input  logic        rx_ready_i,
  output logic        fss_o,
  output logic        sck_o,
  output logic [3:0]  lane_o,
  output logic [3:0]  lane_oe_o,
  input  logic [3:0]  lane_i
);
  logic               tx_full, tx_avail, load, sample, shift, done, rx_push, active, dir_q;
  logic               rx_full;
  logic [ENTRY_W-1:0] tx_entry, rx_entry;
  logic [BYTE_W-1:0]  rx_byte;
  fmt_e               fmt;

  assign tx_ready_o = !tx_full;
  assign rx_entry   = {{(ENTRY_W-BYTE_W){1'b0}}, rx_byte};

  mlss_fifo #(.W(ENTRY_W), .DEPTH(TX_DEPTH)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_valid_i),
    .wdata_i (tx_data_i),
    .full_o  (tx_full),
    .pop_i   (load),
    .valid_o (tx_avail),
    .rdata_o (tx_entry)
  );

  mlss_ctrl #(.SCK_DIV(SCK_DIV)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_valid_i (tx_avail),
    .tx_entry_i (tx_entry),
    .dir_rx_i   (dir_rx_i),
    .load_o     (load),
    .sample_o   (sample),
    .shift_o    (shift),
    .done_o     (done),
    .rx_push_o  (rx_push),
    .active_o   (active),
    .fss_o      (fss_o),
    .sck_o      (sck_o),
    .fmt_o      (fmt),
    .dir_o      (dir_q)
  );

  mlss_shift i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .data_i    (tx_entry[BYTE_W-1:0]),
    .shift_i   (shift),
    .sample_i  (sample),
    .active_i  (active),
    .fmt_i     (fmt),
    .dir_i     (dir_q),
    .lane_i    (lane_i),
    .lane_o    (lane_o),
    .lane_oe_o (lane_oe_o),
    .rx_byte_o (rx_byte)
  );

  // full receive queue drops the byte
  mlss_fifo #(.W(ENTRY_W), .DEPTH(RX_DEPTH)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push && !rx_full),
    .wdata_i (rx_entry),
    .full_o  (rx_full),
    .pop_i   (rx_ready_i),
    .valid_o (rx_valid_o),
    .rdata_o (rx_data_o)
  );

endmodule

// File: rtl/mlss_master_chk.sv
module mlss_master_chk
  import mlss_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fss_o,
  input logic        sck_o,
  input logic [3:0]  lane_o,
  input logic [3:0]  lane_oe_o,
  input logic        rx_push,
  input logic [15:0] rx_entry,
  input fmt_e        fmt,
  input logic        dir_q,
  input logic        active,
  input logic        done
);

  a_r4_lane_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(lane_o));

  a_r6_sck_only_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !fss_o);

  a_r5_fss_moves_sck_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fss_o) |-> !sck_o);

  a_r7_no_rx_tx_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && (fmt != FMT_LEGACY)) |-> dir_q);

  a_r10_legacy_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && (fmt == FMT_LEGACY)) |-> rx_push);

  a_r11_rx_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push |-> (rx_entry[15:8] == 8'h00));

  a_r8_oe_off_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && dir_q && ((fmt == FMT_DUAL) || (fmt == FMT_QUAD))) |-> (lane_oe_o == 4'b0000));

  a_r3_oe_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_oe_o == 4'b0000) || (lane_oe_o == 4'b0001) ||
    (lane_oe_o == 4'b0011) || (lane_oe_o == 4'b1111));

  a_r1_idle_no_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (lane_oe_o == 4'b0000 && !sck_o));

endmodule

bind mlss_master mlss_master_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fss_o     (fss_o),
  .sck_o     (sck_o),
  .lane_o    (lane_o),
  .lane_oe_o (lane_oe_o),
  .rx_push   (rx_push),
  .rx_entry  (rx_entry),
  .fmt       (fmt),
  .dir_q     (dir_q),
  .active    (active),
  .done      (done)
);

// File: tb/test_mlss_master.sv
`timescale 1ns/1ps
module test_mlss_master;
  localparam int SCK_DIV = 4;
  localparam int HALF    = SCK_DIV / 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_valid_i = 1'b0;
  logic [15:0] tx_data_i = '0;
  logic        tx_ready_o;
  logic        dir_rx_i = 1'b0;
  logic        rx_valid_o;
  logic [15:0] rx_data_o;
  logic        rx_ready_i = 1'b0;
  logic        fss_o, sck_o;
  logic [3:0]  lane_o, lane_oe_o, lane_i;

  always #2.5 clk = ~clk;

  mlss_master #(.SCK_DIV(SCK_DIV)) i_mlss_master (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i), .tx_ready_o(tx_ready_o),
    .dir_rx_i(dir_rx_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_ready_i(rx_ready_i),
    .fss_o(fss_o), .sck_o(sck_o), .lane_o(lane_o), .lane_oe_o(lane_oe_o), .lane_i(lane_i)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // serial-edge monitor and remote-device model
  int         rise_n = 0;
  logic [3:0] beat_lane [64];
  logic [3:0] beat_oe   [64];
  int         slv_w = 1;
  logic [7:0] slv_bytes [8];
  int         hi_run = 0, lo_run = 0, hi_bad = 0, lo_bad = 0, fss_rises = 0;
  logic       fss_prev = 1'b1;

  always @(posedge sck_o) begin
    if (rise_n < 64) begin
      beat_lane[rise_n] = lane_o;
      beat_oe[rise_n]   = lane_oe_o;
    end
    rise_n = rise_n + 1;
  end

  always @(negedge clk) begin
    if (sck_o) begin
      if (lo_run > 0 && lo_run < HALF && rise_n > 1) lo_bad = lo_bad + 1;
      lo_run = 0;
      hi_run = hi_run + 1;
    end else begin
      if (hi_run > 0 && hi_run != HALF) hi_bad = hi_bad + 1;
      hi_run = 0;
      lo_run = lo_run + 1;
    end
    if (fss_o && !fss_prev) fss_rises = fss_rises + 1;
    fss_prev = fss_o;
  end

  int         slv_bpb, slv_bi, slv_bt;
  logic [7:0] slv_cur;
  always_comb begin
    slv_bpb = 8 / slv_w;
    slv_bi  = rise_n / slv_bpb;
    slv_bt  = rise_n % slv_bpb;
    slv_cur = slv_bytes[slv_bi[2:0]] >> (8 - slv_w * (slv_bt + 1));
    if (slv_w == 1)      lane_i = {2'b00, slv_cur[0], 1'b0};
    else if (slv_w == 2) lane_i = {2'b00, slv_cur[1:0]};
    else                 lane_i = slv_cur[3:0];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rise_n = 0; hi_bad = 0; lo_bad = 0; fss_rises = 0;
  endtask

  task automatic push(input logic [15:0] e);
    @(negedge clk);
    while (!tx_ready_o) @(negedge clk);
    tx_valid_i = 1'b1;
    tx_data_i  = e;
    @(negedge clk);
    tx_valid_i = 1'b0;
  endtask

  task automatic wait_frame_end(input int beats);
    while (rise_n < beats) @(negedge clk);
    while (!fss_o) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_rx(output bit v, output logic [15:0] d);
    @(negedge clk);
    v = rx_valid_o;
    d = rx_data_o;
    if (v) begin
      rx_ready_i = 1'b1;
      @(negedge clk);
      rx_ready_i = 1'b0;
    end
  endtask

  function automatic int assemble(input int w, input int first);
    int v = 0;
    for (int i = 0; i < 8 / w; i++) v = (v << w) | (int'(beat_lane[first + i]) & ((1 << w) - 1));
    return v & 8'hFF;
  endfunction

  function automatic bit oe_all(input int first, input int n, input logic [3:0] exp);
    bit ok = 1;
    for (int i = 0; i < n; i++) if (beat_oe[first + i] != exp) ok = 0;
    return ok;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(fss_o === 1'b1, "R1 fss", int'(fss_o), 1);
    chk(sck_o === 1'b0, "R1 sck", int'(sck_o), 0);
    chk(lane_oe_o === 4'b0000, "R1 oe", int'(lane_oe_o), 0);
    chk(rx_valid_o === 1'b0, "R1 rx_valid", int'(rx_valid_o), 0);
  endtask

  task automatic t_legacy();
    bit v; logic [15:0] d;
    clear_mon(); slv_w = 1; slv_bytes[0] = 8'h3C; dir_rx_i = 1'b0;
    push(16'h10A5);
    while (fss_o) @(negedge clk);
    chk(rise_n == 0, "R2 fss low before clock", rise_n, 0);
    wait_frame_end(8);
    chk(rise_n == 8, "R10 beat count", rise_n, 8);
    chk(assemble(1, 0) == 8'hA5, "R3 R10 legacy tx byte", assemble(1, 0), 8'hA5);
    chk(oe_all(0, 8, 4'b0001), "R10 lane0 driven", int'(beat_oe[0]), 1);
    chk(hi_bad == 0, "R4 sck high time", hi_bad, 0);
    chk(lo_bad == 0, "R4 sck low time", lo_bad, 0);
    pop_rx(v, d);
    chk(v && d == 16'h003C, "R10 R11 legacy rx in tx dir", int'(d), 16'h003C);
  endtask

  task automatic t_dual_tx();
    bit v; logic [15:0] d;
    clear_mon(); dir_rx_i = 1'b0;
    push(16'h30B4);
    wait_frame_end(4);
    chk(rise_n == 4, "R3 dual beats", rise_n, 4);
    chk(beat_lane[0][1:0] == 2'b10 && beat_lane[3][1:0] == 2'b00, "R3 dual lane order",
        int'(beat_lane[0]), 2);
    chk(assemble(2, 0) == 8'hB4, "R7 dual tx byte", assemble(2, 0), 8'hB4);
    chk(oe_all(0, 4, 4'b0011), "R7 dual oe", int'(beat_oe[0]), 3);
    pop_rx(v, d);
    chk(!v, "R7 no rx in tx dir", int'(v), 0);
  endtask

  task automatic t_quad_rx();
    bit v; logic [15:0] d;
    clear_mon(); slv_w = 4; slv_bytes[0] = 8'h9E; dir_rx_i = 1'b1;
    push(16'h5000);
    while (rise_n < 1) @(negedge clk);
    dir_rx_i = 1'b0;   // must not affect the entry in flight
    wait_frame_end(2);
    chk(rise_n == 2, "R8 quad beats", rise_n, 2);
    chk(oe_all(0, 2, 4'b0000), "R8 R12 quad rx oe off", int'(beat_oe[1]), 0);
    pop_rx(v, d);
    chk(v && d == 16'h009E, "R8 R11 R12 quad rx byte", int'(d), 16'h009E);
  endtask

  task automatic t_quad_tx();
    clear_mon(); dir_rx_i = 1'b0;
    push(16'h50C7);
    wait_frame_end(2);
    chk(beat_lane[0] == 4'hC && beat_lane[1] == 4'h7, "R3 quad nibble order",
        int'({beat_lane[0], beat_lane[1]}), 8'hC7);
    chk(oe_all(0, 2, 4'b1111), "R7 quad oe", int'(beat_oe[0]), 15);
  endtask

  task automatic t_adv();
    bit v; logic [15:0] d;
    clear_mon(); slv_w = 1; slv_bytes[0] = 8'hEE; dir_rx_i = 1'b0;
    push(16'h7081);
    wait_frame_end(8);
    chk(assemble(1, 0) == 8'h81, "R9 adv tx byte", assemble(1, 0), 8'h81);
    pop_rx(v, d);
    chk(!v, "R9 adv tx dir blocks rx", int'(v), 0);
    clear_mon(); slv_bytes[0] = 8'h5A; dir_rx_i = 1'b1;
    push(16'h70C3);
    wait_frame_end(8);
    chk(assemble(1, 0) == 8'hC3, "R9 adv full duplex tx", assemble(1, 0), 8'hC3);
    chk(oe_all(0, 8, 4'b0001), "R9 adv oe", int'(beat_oe[0]), 1);
    pop_rx(v, d);
    chk(v && d == 16'h005A, "R9 adv full duplex rx", int'(d), 16'h005A);
    dir_rx_i = 1'b0;
  endtask

  task automatic t_underrun();
    bit v; logic [15:0] d;
    clear_mon(); slv_w = 1; slv_bytes[0] = 8'h00; slv_bytes[1] = 8'hFF; dir_rx_i = 1'b0;
    push(16'h0011);
    while (rise_n < 8) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(fss_o === 1'b0, "R6 fss held low", int'(fss_o), 0);
    chk(rise_n == 8, "R6 no clock on empty", rise_n, 8);
    chk(sck_o === 1'b0, "R6 sck low", int'(sck_o), 0);
    push(16'h1022);
    wait_frame_end(16);
    chk(fss_rises == 1, "R5 single fss rise", fss_rises, 1);
    chk(assemble(1, 0) == 8'h11 && assemble(1, 8) == 8'h22, "R5 two bytes one frame",
        assemble(1, 8), 8'h22);
    pop_rx(v, d);
    chk(v && d == 16'h0000, "R10 first rx", int'(d), 0);
    pop_rx(v, d);
    chk(v && d == 16'h00FF, "R10 R11 second rx", int'(d), 16'h00FF);
  endtask

  initial begin
    slv_bytes = '{default: 8'h00};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_legacy();
    t_dual_tx();
    t_quad_rx();
    t_quad_tx();
    t_adv();
    t_underrun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule